// File: doc/BRIEF.md
# SDRAM Initialisation and Refresh Sequencer

This block owns the command pins of a low-power SDR SDRAM from reset onward. After reset it raises the clock enable and holds the bus at NOP for a programmable settling period. It then closes every bank, issues two refresh commands, and writes the mode register and the extended mode register. Only after that does it report that the memory is ready.

In normal operation a cycle counter marks one refresh as due at a fixed interval, set as a parameter in clock cycles. Due refreshes are counted. A simple user command port, which carries a valid flag, the RAS/CAS/WE levels, a bank and an address, wins the bus while few refreshes are owed. Once the owed count reaches a limit, refresh takes the bus ahead of the user. Each refresh closes all banks first, waits out the precharge time, issues the refresh and then waits out the refresh cycle time. The bus then returns to the user.

Top module: `sdr_initref_ctrl`

## Requirements
- R1: While reset is asserted, clock enable is low, chip select is high (command inhibit), and `init_done`, `ref_busy` and `usr_ready` are all low.
- R2: From the first clock after reset, clock enable is high and stays high. Exactly PWRUP_CYC NOP cycles (CS low, RAS/CAS/WE high) pass before the first other command.
- R3: The first command after the NOP period is a precharge of all banks (CS, RAS and WE low, CAS high, address bit 10 high). T_RP NOP cycles follow it.
- R4: Two refresh commands (CS, RAS and CAS low, WE high) come next. Each one is followed by T_RFC NOP cycles.
- R5: Next comes a mode register load (all four control lines low) with bank 0. Its address carries the burst length code in bits 2:0, the interleave flag in bit 3 and the CAS latency (2 or 3) in bits 6:4, with every other bit zero. T_MRD NOP cycles follow it.
- R6: Next comes a mode register load with bank 2 (binary 10) and address EXT_OP, followed by T_MRD NOP cycles. `init_done` rises in the cycle of the last of those NOPs and stays high until reset.
- R7: `usr_ready` is low and no user command reaches the bus until `init_done` is high.
- R8: When `usr_valid` and `usr_ready` are both high at a clock edge, the user command appears on the bus in the next cycle: CS low, the given RAS/CAS/WE levels, bank and address.
- R9: A refresh runs as a precharge of all banks, then exactly T_RP NOPs, then a refresh command, then at least T_RFC NOPs. `ref_busy` is high and `usr_ready` is low throughout.
- R10: After `init_done`, one refresh becomes due every REF_INT cycles. With the user port idle, consecutive refresh precharges are exactly REF_INT cycles apart.
- R11: While fewer than PEND_LIMIT refreshes are owed, a valid user command is served ahead of a due refresh. At PEND_LIMIT owed, `usr_ready` drops and the refresh runs while `usr_valid` is held. Owed refreshes run as soon as the user port goes idle.
- R12: Every refresh command on the bus is preceded by an all-bank precharge, with no activate, read, write, burst stop or mode load in between. When nothing is owed and no user command is valid, the bus shows NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller and SDRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_valid | input | 1 | User command present |
| usr_ras_n | input | 1 | User RAS level |
| usr_cas_n | input | 1 | User CAS level |
| usr_we_n | input | 1 | User WE level |
| usr_ba | input | BA_W | User bank address |
| usr_addr | input | ADDR_W | User address |
| usr_ready | output | 1 | User command will be taken at this edge |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | BA_W | SDRAM bank address |
| sd_addr | output | ADDR_W | SDRAM address bus |
| init_done | output | 1 | Initialisation finished |
| ref_busy | output | 1 | Refresh sequence owns the bus |

## Verification
A wrong wait count or a bad state transition shows on the command pins within a few cycles. During start-up, every command lands at a fixed cycle offset from reset, so a slip of one cycle gives a mismatch against the expected schedule at the next non-NOP command. An error in the interval counter or the owed-refresh counter shows up later, about one refresh interval after the fault. It appears as unequal spacing of idle refreshes, a refresh that preempts the user too early or too late, or a missing catch-up refresh after the user port goes idle.

// File: rtl/sdr_ir_pkg.sv
package sdr_ir_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_INH = 4'b1111;
    localparam sd_cmd_t CMD_NOP = 4'b0111;
    localparam sd_cmd_t CMD_PRE = 4'b0010;
    localparam sd_cmd_t CMD_REF = 4'b0001;
    localparam sd_cmd_t CMD_LMR = 4'b0000;
    localparam sd_cmd_t CMD_ACT = 4'b0011;
    localparam sd_cmd_t CMD_RD  = 4'b0101;
    localparam sd_cmd_t CMD_WR  = 4'b0100;
    localparam sd_cmd_t CMD_BST = 4'b0110;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_PRE_INIT,
        ST_REF_A,
        ST_REF_B,
        ST_LMR,
        ST_EMR,
        ST_WAIT,
        ST_IDLE,
        ST_RREF
    } seq_st_e;

    // Mode word: [2:0] burst code, [3] interleave, [6:4] CAS latency,
    // [8:7] operating mode (standard), [9] write burst follows reads, [11:10] zero.
    function automatic logic [11:0] mode_word(input logic [2:0] bl_code,
                                              input logic       ilv,
                                              input logic [2:0] cl);
        return {2'b00, 1'b0, 2'b00, cl, ilv, bl_code};
    endfunction

endpackage

// File: rtl/sdr_ir_ticker.sv
module sdr_ir_ticker #(
    parameter int REF_INT = 2080
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = (REF_INT > 2) ? $clog2(REF_INT) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          tick;
    } tk_s;

    tk_s tk_d, tk_q;

    always_comb begin
        tk_d      = tk_q;
        tk_d.tick = 1'b0;
        if (!en) begin
            tk_d.cnt = '0;
        end else if (tk_q.cnt == TW'(REF_INT - 1)) begin
            tk_d.cnt  = '0;
            tk_d.tick = 1'b1;
        end else begin
            tk_d.cnt = tk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end

    assign tick = tk_q.tick;

    // R10: a due-refresh mark is a single-cycle pulse
    a_r10_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tk_q.tick |=> !tk_q.tick);

    // R10: no refresh is marked due before initialisation completes
    a_r10_quiet_before_init: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !tk_q.tick) |=> !tk_q.tick);

endmodule

// File: rtl/sdr_ir_pending.sv
module sdr_ir_pending #(
    parameter int MAX_PEND   = 8,
    parameter int PEND_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic dec,
    output logic nz,
    output logic urgent
);
    localparam int PW = $clog2(MAX_PEND + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pd_s;

    pd_s pd_d, pd_q;

    always_comb begin
        pd_d = pd_q;
        unique case ({tick, dec})
            2'b10: if (pd_q.cnt != PW'(MAX_PEND)) pd_d.cnt = pd_q.cnt + 1'b1;
            2'b01: if (pd_q.cnt != '0)            pd_d.cnt = pd_q.cnt - 1'b1;
            default: pd_d = pd_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pd_q <= '0;
        else        pd_q <= pd_d;
    end

    assign nz     = (pd_q.cnt != '0);
    assign urgent = (pd_q.cnt >= PW'(PEND_LIMIT));

    // R11: the owed count never passes its ceiling
    a_r11_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pd_q.cnt <= PW'(MAX_PEND));

    // R11: the sequencer only spends a refresh that is actually owed
    a_r11_dec_only_when_owed: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (pd_q.cnt != '0));

endmodule

// File: rtl/sdr_ir_seq.sv
module sdr_ir_seq
    import sdr_ir_pkg::*;
#(
    parameter int                 ADDR_W    = 12,
    parameter int                 BA_W      = 2,
    parameter int                 PWRUP_CYC = 26600,
    parameter int                 T_RP      = 3,
    parameter int                 T_RFC     = 10,
    parameter int                 T_MRD     = 2,
    parameter logic [ADDR_W-1:0]  MODE_OP   = '0,
    parameter logic [ADDR_W-1:0]  EXT_OP    = '0,
    parameter logic [BA_W-1:0]    EXT_BA    = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_valid,
    input  logic              usr_ras_n,
    input  logic              usr_cas_n,
    input  logic              usr_we_n,
    input  logic [BA_W-1:0]   usr_ba,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic              pend_nz,
    input  logic              pend_urgent,
    output logic              usr_ready,
    output logic              ref_issued,
    output logic              sd_cke,
    output sd_cmd_t           sd_cmd,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done,
    output logic              ref_busy
);
    localparam int M1      = (T_RP > T_RFC) ? T_RP : T_RFC;
    localparam int M2      = (M1 > T_MRD) ? M1 : T_MRD;
    localparam int CNT_MAX = (M2 > PWRUP_CYC) ? M2 : PWRUP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int A_ALL   = 10;

    typedef struct packed {
        seq_st_e           st;
        seq_st_e           ret;
        logic [CNT_W-1:0]  cnt;
        logic              cke;
        sd_cmd_t           cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
        logic              busy;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d      = q;
        d.cke  = 1'b1;
        d.cmd  = CMD_NOP;
        d.ba   = '0;
        d.addr = '0;
        unique case (q.st)
            ST_PWRUP: begin
                if (q.cnt == '0) d.st  = ST_PRE_INIT;
                else             d.cnt = q.cnt - 1'b1;
            end
            ST_PRE_INIT: begin
                d.cmd         = CMD_PRE;
                d.addr[A_ALL] = 1'b1;
                d.st          = ST_WAIT;
                d.cnt         = CNT_W'(T_RP - 1);
                d.ret         = ST_REF_A;
            end
            ST_REF_A: begin
                d.cmd = CMD_REF;
                d.st  = ST_WAIT;
                d.cnt = CNT_W'(T_RFC - 1);
                d.ret = ST_REF_B;
            end
            ST_REF_B: begin
                d.cmd = CMD_REF;
                d.st  = ST_WAIT;
                d.cnt = CNT_W'(T_RFC - 1);
                d.ret = ST_LMR;
            end
            ST_LMR: begin
                d.cmd  = CMD_LMR;
                d.addr = MODE_OP;
                d.st   = ST_WAIT;
                d.cnt  = CNT_W'(T_MRD - 1);
                d.ret  = ST_EMR;
            end
            ST_EMR: begin
                d.cmd  = CMD_LMR;
                d.ba   = EXT_BA;
                d.addr = EXT_OP;
                d.st   = ST_WAIT;
                d.cnt  = CNT_W'(T_MRD - 1);
                d.ret  = ST_IDLE;
            end
            ST_WAIT: begin
                if (q.cnt == '0) begin
                    d.st = q.ret;
                    if (q.ret == ST_IDLE) begin
                        d.done = 1'b1;
                        d.busy = 1'b0;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_IDLE: begin
                if (pend_urgent || (pend_nz && !usr_valid)) begin
                    d.cmd         = CMD_PRE;
                    d.addr[A_ALL] = 1'b1;
                    d.busy        = 1'b1;
                    d.st          = ST_WAIT;
                    d.cnt         = CNT_W'(T_RP - 1);
                    d.ret         = ST_RREF;
                end else if (usr_valid) begin
                    d.cmd  = '{cs_n: 1'b0, ras_n: usr_ras_n, cas_n: usr_cas_n, we_n: usr_we_n};
                    d.ba   = usr_ba;
                    d.addr = usr_addr;
                end
            end
            ST_RREF: begin
                d.cmd = CMD_REF;
                d.st  = ST_WAIT;
                d.cnt = CNT_W'(T_RFC - 1);
                d.ret = ST_IDLE;
            end
            default: d.st = ST_PWRUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_PWRUP;
            q.ret  <= ST_IDLE;
            q.cnt  <= CNT_W'(PWRUP_CYC - 1);
            q.cke  <= 1'b0;
            q.cmd  <= CMD_INH;
        end else begin
            q <= d;
        end
    end

    assign usr_ready  = (q.st == ST_IDLE) && !pend_urgent;
    assign ref_issued = (q.st == ST_RREF);
    assign sd_cke     = q.cke;
    assign sd_cmd     = q.cmd;
    assign sd_ba      = q.ba;
    assign sd_addr    = q.addr;
    assign init_done  = q.done;
    assign ref_busy   = q.busy;

    // Checker state: all banks known closed since the last bank-opening command
    logic pre_armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_armed_q <= 1'b0;
        end else if (q.cmd == CMD_PRE && q.addr[A_ALL]) begin
            pre_armed_q <= 1'b1;
        end else if (q.cmd == CMD_ACT || q.cmd == CMD_RD || q.cmd == CMD_WR ||
                     q.cmd == CMD_LMR || q.cmd == CMD_BST) begin
            pre_armed_q <= 1'b0;
        end
    end

    // R12: a refresh only follows an all-bank precharge
    a_r12_ref_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_REF) |-> pre_armed_q);

    // R7: the user port opens only once initialisation has finished
    a_r7_ready_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        usr_ready |-> q.done);

    // R9: the user port is shut while a refresh owns the bus
    a_r9_busy_blocks_user: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> !usr_ready);

    // R6: ready indication never falls outside reset
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> q.done);

    // R2: clock enable stays high once raised
    a_r2_cke_held: assert property (@(posedge clk) disable iff (!rst_n)
        q.cke |=> q.cke);

    // R3: a counting wait keeps NOP on the bus
    a_r3_wait_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && q.cnt != '0) |=> (q.cmd == CMD_NOP));

endmodule

// File: rtl/sdr_initref_ctrl.sv
module sdr_initref_ctrl
    import sdr_ir_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          BA_W       = 2,
    parameter int          PWRUP_CYC  = 26600,
    parameter int          REF_INT    = 2080,
    parameter int          T_RP       = 3,
    parameter int          T_RFC      = 10,
    parameter int          T_MRD      = 2,
    parameter int          MAX_PEND   = 8,
    parameter int          PEND_LIMIT = 4,
    parameter int          CAS_LAT    = 3,
    parameter logic [2:0]  BURST_CODE = 3'b011,
    parameter logic        BURST_ILV  = 1'b0,
    parameter logic [11:0] EXT_OP     = 12'h000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_valid,
    input  logic              usr_ras_n,
    input  logic              usr_cas_n,
    input  logic              usr_we_n,
    input  logic [BA_W-1:0]   usr_ba,
    input  logic [ADDR_W-1:0] usr_addr,
    output logic              usr_ready,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done,
    output logic              ref_busy
);
    localparam logic [ADDR_W-1:0] MODE_W =
        ADDR_W'(mode_word(BURST_CODE, BURST_ILV, 3'(CAS_LAT)));
    localparam logic [ADDR_W-1:0] EXT_W  = ADDR_W'(EXT_OP);
    localparam logic [BA_W-1:0]   EXT_BA = BA_W'(2);

    logic    tick, pend_nz, pend_urgent, ref_issued;
    sd_cmd_t cmd;

    sdr_ir_ticker #(.REF_INT(REF_INT)) u_ticker (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .tick  (tick)
    );

    sdr_ir_pending #(.MAX_PEND(MAX_PEND), .PEND_LIMIT(PEND_LIMIT)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .dec    (ref_issued),
        .nz     (pend_nz),
        .urgent (pend_urgent)
    );

    sdr_ir_seq #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .PWRUP_CYC (PWRUP_CYC),
        .T_RP      (T_RP),
        .T_RFC     (T_RFC),
        .T_MRD     (T_MRD),
        .MODE_OP   (MODE_W),
        .EXT_OP    (EXT_W),
        .EXT_BA    (EXT_BA)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .usr_valid   (usr_valid),
        .usr_ras_n   (usr_ras_n),
        .usr_cas_n   (usr_cas_n),
        .usr_we_n    (usr_we_n),
        .usr_ba      (usr_ba),
        .usr_addr    (usr_addr),
        .pend_nz     (pend_nz),
        .pend_urgent (pend_urgent),
        .usr_ready   (usr_ready),
        .ref_issued  (ref_issued),
        .sd_cke      (sd_cke),
        .sd_cmd      (cmd),
        .sd_ba       (sd_ba),
        .sd_addr     (sd_addr),
        .init_done   (init_done),
        .ref_busy    (ref_busy)
    );

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;

endmodule

// File: tb/tb_sdr_initref_ctrl.sv
module tb_sdr_initref_ctrl;

    localparam int P_PWR   = 20;
    localparam int P_INT   = 200;
    localparam int P_RP    = 2;
    localparam int P_RFC   = 5;
    localparam int P_MRD   = 2;
    localparam logic [11:0] P_EXT  = 12'h020;
    localparam logic [11:0] P_MODE = 12'h033; // CL=3 in [6:4], burst code 011 in [2:0]

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        usr_valid = 1'b0;
    logic        usr_ras_n = 1'b1, usr_cas_n = 1'b1, usr_we_n = 1'b1;
    logic [1:0]  usr_ba = '0;
    logic [11:0] usr_addr = '0;
    logic        usr_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic        init_done, ref_busy;

    always #2.5 clk = ~clk;

    sdr_initref_ctrl #(
        .PWRUP_CYC(P_PWR), .REF_INT(P_INT), .T_RP(P_RP), .T_RFC(P_RFC), .T_MRD(P_MRD),
        .MAX_PEND(4), .PEND_LIMIT(2), .CAS_LAT(3), .BURST_CODE(3'b011),
        .BURST_ILV(1'b0), .EXT_OP(P_EXT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .usr_valid(usr_valid), .usr_ras_n(usr_ras_n),
        .usr_cas_n(usr_cas_n), .usr_we_n(usr_we_n), .usr_ba(usr_ba), .usr_addr(usr_addr),
        .usr_ready(usr_ready), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .init_done(init_done), .ref_busy(ref_busy)
    );

    typedef struct {
        logic [3:0]  code;
        logic [1:0]  ba;
        logic [11:0] addr;
        logic [11:0] mask;
        int          at;
        string       tag;
    } exp_t;

    exp_t  expq[$];
    int    pre_list[$];
    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    ended = 0;
    bit    ref_armed = 0;
    int    ref_pre_at = 0;
    int    guard_until = -1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wrap();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic push(input logic [3:0] code, input logic [1:0] ba, input logic [11:0] a,
                        input logic [11:0] m, input int at, input string tag);
        exp_t e;
        e.code = code; e.ba = ba; e.addr = a; e.mask = m; e.at = at; e.tag = tag;
        expq.push_back(e);
    endtask

    // Driver: call at a negedge; holds valid until the command is taken
    task automatic send(input logic [2:0] rcw, input logic [1:0] ba, input logic [11:0] a);
        bit taken = 0;
        usr_valid = 1'b1;
        {usr_ras_n, usr_cas_n, usr_we_n} = rcw;
        usr_ba = ba;
        usr_addr = a;
        while (!taken) begin
            if (usr_ready) begin
                push({1'b0, rcw}, ba, a, 12'hFFF, cyc + 1, "R8");
                taken = 1;
            end
            @(negedge clk);
        end
        usr_valid = 1'b0;
    endtask

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Monitor / scoreboard
    always @(negedge clk) begin
        logic [3:0] code;
        if (rst_n && !ended && cyc >= 1) begin
            code = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (!sd_cke) chk(0, "R2", "cke low after reset", 0, 1);
            if (!init_done && usr_ready) chk(0, "R7", "ready before init", 1, 0);
            if (ref_armed && cyc > ref_pre_at + P_RP + 1) begin
                chk(0, "R9", "refresh missing after precharge", cyc, ref_pre_at + P_RP + 1);
                ref_armed = 0;
            end
            if (code != 4'b0111) begin
                if (ref_armed) begin
                    chk(code == 4'b0001, "R9", "refresh code", code, 1);
                    chk(cyc == ref_pre_at + P_RP + 1, "R9", "refresh cycle", cyc, ref_pre_at + P_RP + 1);
                    chk(ref_busy == 1'b1, "R9", "busy at refresh", ref_busy, 1);
                    guard_until = cyc + P_RFC;
                    ref_armed = 0;
                end else if (cyc <= guard_until) begin
                    chk(0, "R9", "command inside refresh recovery", code, 7);
                end else if (init_done && code == 4'b0010 && sd_addr[10]) begin
                    ref_armed = 1;
                    ref_pre_at = cyc;
                    pre_list.push_back(cyc);
                    chk(ref_busy == 1'b1, "R9", "busy at precharge", ref_busy, 1);
                    chk(usr_ready == 1'b0, "R9", "ready during refresh", usr_ready, 0);
                end else if (expq.size() == 0) begin
                    chk(0, "R12", "unexpected command", code, 7);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(code == e.code && sd_ba == e.ba && ((sd_addr & e.mask) == (e.addr & e.mask)),
                        e.tag, "command fields", {code, sd_ba, sd_addr}, {e.code, e.ba, e.addr & e.mask});
                    chk(cyc == e.at, e.tag, "command cycle", cyc, e.at);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "R12", "watchdog expired", cyc, 0);
        wrap();
    end

    initial begin
        int pre_at, r1, r2, lm, em, dn, done_at, hold_start, base, rel, n, d;
        pre_at = P_PWR + 1;
        r1 = pre_at + P_RP + 1;
        r2 = r1 + P_RFC + 1;
        lm = r2 + P_RFC + 1;
        em = lm + P_MRD + 1;
        dn = em + P_MRD;
        push(4'b0010, 2'b00, 12'h400, 12'h400, pre_at, "R3");
        push(4'b0001, 2'b00, 12'h000, 12'h000, r1, "R4");
        push(4'b0001, 2'b00, 12'h000, 12'h000, r2, "R4");
        push(4'b0000, 2'b00, P_MODE, 12'hFFF, lm, "R5");
        push(4'b0000, 2'b10, P_EXT, 12'hFFF, em, "R6");

        repeat (4) @(negedge clk);
        chk(sd_cke == 1'b0, "R1", "cke in reset", sd_cke, 0);
        chk(sd_cs_n == 1'b1, "R1", "cs in reset", sd_cs_n, 1);
        chk(init_done == 1'b0 && ref_busy == 1'b0, "R1", "flags in reset", {init_done, ref_busy}, 0);
        chk(usr_ready == 1'b0, "R1", "ready in reset", usr_ready, 0);

        // R7: a user request held through initialisation must not leak
        usr_valid = 1'b1;
        {usr_ras_n, usr_cas_n, usr_we_n} = 3'b101;
        rst_n = 1'b1;
        done_at = -1;
        while (done_at < 0) begin
            @(negedge clk);
            if (init_done) done_at = cyc;
        end
        chk(done_at == dn, "R6", "init_done rise cycle", done_at, dn);
        chk(expq.size() == 0, "R7", "init commands all seen", expq.size(), 0);
        usr_valid = 1'b0;

        // R8: assorted user commands
        send(3'b011, 2'b01, 12'h123);
        send(3'b100, 2'b10, 12'h045);
        send(3'b101, 2'b11, 12'h0FF);
        send(3'b010, 2'b00, 12'h000);
        send(3'b101, 2'b01, 12'hABC);
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R8", "user commands drained", expq.size(), 0);

        // R10: idle refreshes evenly spaced
        while (pre_list.size() < 3) @(negedge clk);
        n = pre_list.size();
        chk(pre_list[n-1] - pre_list[n-2] == P_INT, "R10", "refresh spacing",
            pre_list[n-1] - pre_list[n-2], P_INT);
        chk(pre_list[0] > done_at && pre_list[0] <= done_at + P_INT + 3, "R10",
            "first refresh delay", pre_list[0] - done_at, P_INT);

        // R11: user priority until the owed limit, then forced refresh
        while (ref_busy) @(negedge clk);
        hold_start = cyc;
        base = pre_list.size();
        while (cyc < hold_start + 2 * P_INT + 20) begin
            send(3'b101, 2'b10, 12'(cyc));
        end
        rel = cyc;
        chk(pre_list.size() == base + 1, "R11", "forced refresh count", pre_list.size(), base + 1);
        if (pre_list.size() > base) begin
            d = pre_list[base] - hold_start;
            chk(d > P_INT && d <= 2 * P_INT + 5, "R11", "forced refresh delay", d, 2 * P_INT);
        end
        repeat (12) @(negedge clk);
        chk(pre_list.size() == base + 2, "R11", "catch-up refresh count", pre_list.size(), base + 2);
        if (pre_list.size() == base + 2)
            chk(pre_list[base+1] > rel && pre_list[base+1] <= rel + 5, "R11",
                "catch-up refresh delay", pre_list[base+1] - rel, 1);

        repeat (20) @(negedge clk);
        chk(expq.size() == 0, "R12", "scoreboard empty", expq.size(), 0);
        chk(init_done == 1'b1, "R6", "init_done held", init_done, 1);
        wrap();
    end

endmodule